// File: doc/BRIEF.md
# One-Wire Bus Master Slot Engine

This block is the bit-level master for a single open-drain one-wire line. Each request from upstream becomes one or eight complete master-initiated time slots on the line: write-0 slots, write-1 slots or read slots. The line level is sampled inside read slots. The block only ever pulls the line low through an enable output, and the external pull-up restores the high level. The line level comes back through a two-stage synchronizer before it is used.

Upstream issues one request at a time with a valid/ready handshake. A request can be a single bit to write, a single bit to read, a byte to write or a byte to read. Bytes go out and come in least significant bit first. To poll a slave, upstream repeats single-bit read requests; each one produces a full slot. When the final slot's recovery time ends, the block gives a one-cycle response pulse. All timing is a fixed number of microseconds multiplied by a ticks-per-microsecond parameter. The defaults are:

- 2 µs short low pulse
- 13 µs read sample point
- 65 µs write-0 low time
- 70 µs slot length

Top module: `ow_master`

## Requirements
- R1: A write-0 slot holds `bus_pull_low` high for exactly ZERO_LOW_US·TICKS_PER_US cycles from the slot start, then releases it. The line is therefore low at both 15 µs and 60 µs after the slot start.
- R2: A write-1 slot or a read slot holds `bus_pull_low` high for exactly SHORT_LOW_US·TICKS_PER_US cycles, then releases it. In a write-1 slot the line is therefore high at 15 µs and at 60 µs.
- R3: Each slot occupies SLOT_US·TICKS_PER_US cycles, measured from the first low cycle. The line stays released for the rest of the slot. The next slot can begin no earlier than one cycle after that.
- R4: A single-bit read returns the line level seen through the synchronizer at tick SAMPLE_US·TICKS_PER_US of the slot. The result is placed in `rsp_data[0]`, and `rsp_data[7:1]` are zero.
- R5: A byte write (`req_op`=2) sends `req_data` as eight back-to-back slots, bit 0 first. Each bit uses the write-1 or write-0 slot shape that matches its value.
- R6: A byte read (`req_op`=3) runs eight read slots. The bit sampled in slot k goes to `rsp_data[k]`.
- R7: `rsp_valid` is high for exactly one cycle, in the cycle right after the last slot ends. For write requests (`req_op`=0 single write of `req_data[0]`, `req_op`=2) `rsp_data` is zero.
- R8: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. The first slot starts on the next edge after acceptance. `req_ready` stays low from acceptance until the response cycle. While it is low, `req_valid` starts no slot.
- R9: While `rst` is high, `bus_pull_low` and `rsp_valid` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_op | input | 2 | 0 write bit, 1 read bit, 2 write byte, 3 read byte |
| req_data | input | 8 | Byte to write; bit 0 for single-bit writes |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_data | output | 8 | Read result, zero for writes |
| bus_pull_low | output | 1 | Open-drain enable: 1 pulls the line low |
| bus_in | input | 1 | Raw line level (asynchronous) |

## Verification
The completion pulse and the acceptance of the next request can happen in the same cycle. `req_ready` rises together with `rsp_valid`, so a request that upstream has been holding is taken on the edge that closes the response cycle. The bench provokes this by issuing requests back to back with `req_valid` held throughout. Every cycle, a behavioural timeline of expected slot starts compares `rsp_valid`, `rsp_data`, `req_ready` and the pull enable against the design. This check confirms that no slot is lost, merged or moved by the overlap.

// File: rtl/ow_pkg.sv
package ow_pkg;

    typedef enum logic [1:0] {
        OP_WBIT  = 2'd0,
        OP_RBIT  = 2'd1,
        OP_WBYTE = 2'd2,
        OP_RBYTE = 2'd3
    } ow_op_e;

    typedef enum logic [1:0] {
        SLOT_W0 = 2'd0,
        SLOT_W1 = 2'd1,
        SLOT_RD = 2'd2
    } slot_kind_e;

    typedef struct packed {
        logic       start;
        slot_kind_e kind;
    } slot_cmd_t;

    function automatic int unsigned us_to_ticks(int unsigned us, int unsigned tpu);
        return us * tpu;
    endfunction

    function automatic logic op_is_read(ow_op_e op);
        return (op == OP_RBIT) || (op == OP_RBYTE);
    endfunction

    function automatic logic op_is_byte(ow_op_e op);
        return (op == OP_WBYTE) || (op == OP_RBYTE);
    endfunction

endpackage

// File: rtl/ow_sync.sv
module ow_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= 1'b1;
                else     chain <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/ow_slot_gen.sv
module ow_slot_gen
    import ow_pkg::*;
#(
    parameter int unsigned CNT_W    = 9,
    parameter int unsigned LOW1_T   = 8,
    parameter int unsigned LOW0_T   = 260,
    parameter int unsigned SAMPLE_T = 52,
    parameter int unsigned SLOT_T   = 280
) (
    input  logic      clk,
    input  logic      rst,
    input  slot_cmd_t cmd,
    input  logic      line_sync,
    output logic      busy,
    output logic      done,
    output logic      rd_bit,
    output logic      pull_low
);
    localparam logic [CNT_W-1:0] LAST_C   = CNT_W'(SLOT_T - 1);
    localparam logic [CNT_W-1:0] SAMPLE_C = CNT_W'(SAMPLE_T);
    localparam logic [CNT_W-1:0] LOW1_C   = CNT_W'(LOW1_T);
    localparam logic [CNT_W-1:0] LOW0_C   = CNT_W'(LOW0_T);

    logic [CNT_W-1:0] cnt;
    slot_kind_e       kind_q;
    logic [CNT_W-1:0] low_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            cnt    <= '0;
            kind_q <= SLOT_W1;
            rd_bit <= 1'b1;
        end else if (!busy) begin
            if (cmd.start) begin
                busy   <= 1'b1;
                cnt    <= '0;
                kind_q <= cmd.kind;
            end
        end else begin
            if (cnt == LAST_C) busy <= 1'b0;
            else               cnt  <= cnt + 1'b1;
            if (kind_q == SLOT_RD && cnt == SAMPLE_C) rd_bit <= line_sync;
        end
    end

    always_comb begin
        low_len  = (kind_q == SLOT_W0) ? LOW0_C : LOW1_C;
        pull_low = busy && (cnt < low_len);
        done     = busy && (cnt == LAST_C);
    end
endmodule

// File: rtl/ow_byte_ctl.sv
module ow_byte_ctl
    import ow_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    output logic       req_ready,
    input  logic [1:0] req_op,
    input  logic [7:0] req_data,
    input  logic       slot_busy,
    input  logic       slot_done,
    input  logic       slot_bit,
    output slot_cmd_t  cmd,
    output logic       rsp_valid,
    output logic [7:0] rsp_data
);
    ow_op_e     op;
    logic       active, rd_mode, byte_mode;
    logic [7:0] txsh, rxsh;
    logic [3:0] left;

    assign op        = ow_op_e'(req_op);
    assign req_ready = !active;

    always_comb begin
        cmd.start = active && !slot_busy;
        cmd.kind  = rd_mode ? SLOT_RD : (txsh[0] ? SLOT_W1 : SLOT_W0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            rd_mode   <= 1'b0;
            byte_mode <= 1'b0;
            txsh      <= '0;
            rxsh      <= '0;
            left      <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (req_valid && !active) begin
                active    <= 1'b1;
                rd_mode   <= op_is_read(op);
                byte_mode <= op_is_byte(op);
                txsh      <= req_data;
                rxsh      <= '0;
                left      <= op_is_byte(op) ? 4'd8 : 4'd1;
            end else if (active && slot_done) begin
                txsh <= txsh >> 1;
                rxsh <= {slot_bit, rxsh[7:1]};
                left <= left - 1'b1;
                if (left == 4'd1) begin
                    active    <= 1'b0;
                    rsp_valid <= 1'b1;
                    if (!rd_mode)       rsp_data <= '0;
                    else if (byte_mode) rsp_data <= {slot_bit, rxsh[7:1]};
                    else                rsp_data <= {7'd0, slot_bit};
                end
            end
        end
    end
endmodule

// File: rtl/ow_master.sv
module ow_master
    import ow_pkg::*;
#(
    parameter int unsigned TICKS_PER_US = 50,
    parameter int unsigned SHORT_LOW_US = 2,
    parameter int unsigned SAMPLE_US    = 13,
    parameter int unsigned ZERO_LOW_US  = 65,
    parameter int unsigned SLOT_US      = 70,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    output logic       req_ready,
    input  logic [1:0] req_op,
    input  logic [7:0] req_data,
    output logic       rsp_valid,
    output logic [7:0] rsp_data,
    output logic       bus_pull_low,
    input  logic       bus_in
);
    localparam int unsigned LOW1_T   = us_to_ticks(SHORT_LOW_US, TICKS_PER_US);
    localparam int unsigned SAMPLE_T = us_to_ticks(SAMPLE_US, TICKS_PER_US);
    localparam int unsigned LOW0_T   = us_to_ticks(ZERO_LOW_US, TICKS_PER_US);
    localparam int unsigned SLOT_T   = us_to_ticks(SLOT_US, TICKS_PER_US);
    localparam int unsigned CNT_W    = $clog2(SLOT_T + 1);

    logic      line_sync, slot_busy, slot_done, slot_bit;
    slot_cmd_t cmd;

    ow_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (bus_in),
        .dout(line_sync)
    );

    ow_byte_ctl u_ctl (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req_ready(req_ready),
        .req_op   (req_op),
        .req_data (req_data),
        .slot_busy(slot_busy),
        .slot_done(slot_done),
        .slot_bit (slot_bit),
        .cmd      (cmd),
        .rsp_valid(rsp_valid),
        .rsp_data (rsp_data)
    );

    ow_slot_gen #(
        .CNT_W   (CNT_W),
        .LOW1_T  (LOW1_T),
        .LOW0_T  (LOW0_T),
        .SAMPLE_T(SAMPLE_T),
        .SLOT_T  (SLOT_T)
    ) u_slot (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .line_sync(line_sync),
        .busy     (slot_busy),
        .done     (slot_done),
        .rd_bit   (slot_bit),
        .pull_low (bus_pull_low)
    );
endmodule

// File: rtl/ow_master_chk.sv
module ow_master_chk #(
    parameter int unsigned LOW0_T = 260,
    parameter int unsigned SLOT_T = 280,
    parameter int unsigned CW     = 9
) (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic req_ready,
    input logic bus_pull_low,
    input logic rsp_valid
);
    localparam logic [CW-1:0] SLOT_C = CW'(SLOT_T);
    localparam logic [CW-1:0] LOW0_C = CW'(LOW0_T);

    logic          pull_q;
    logic [CW-1:0] since_rise, low_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            pull_q     <= 1'b0;
            since_rise <= SLOT_C;
            low_run    <= '0;
        end else begin
            pull_q <= bus_pull_low;
            if (bus_pull_low && !pull_q)  since_rise <= CW'(1);
            else if (since_rise < SLOT_C) since_rise <= since_rise + 1'b1;
            if (!bus_pull_low)            low_run <= '0;
            else if (low_run < LOW0_C)    low_run <= low_run + 1'b1;
        end
    end

    // R8
    accept_drops_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);
    // R7
    rsp_single_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);
    // R7
    rsp_with_ready_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> req_ready);
    // R2
    min_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_pull_low) |=> bus_pull_low);
    // R1
    max_low_chk: assert property (@(posedge clk) disable iff (rst)
        bus_pull_low |-> (low_run < LOW0_C));
    // R3
    slot_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_pull_low) |-> (since_rise >= SLOT_C));
endmodule

bind ow_master ow_master_chk #(
    .LOW0_T(LOW0_T),
    .SLOT_T(SLOT_T),
    .CW    (CNT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .bus_pull_low(bus_pull_low),
    .rsp_valid   (rsp_valid)
);

// File: tb/tb_ow_master.sv
module tb_ow_master;
    localparam int TPU  = 4;
    localparam int LOW1 = 2 * TPU;
    localparam int LOW0 = 65 * TPU;
    localparam int SLOT = 70 * TPU;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [1:0] req_op = 2'd0;
    logic [7:0] req_data = 8'd0;
    logic       req_ready, rsp_valid, bus_pull_low;
    logic [7:0] rsp_data;
    logic       slave_low = 1'b0;
    wire        bus_line = !(bus_pull_low || slave_low);

    always #2 clk = ~clk;

    ow_master #(.TICKS_PER_US(TPU)) dut (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_op      (req_op),
        .req_data    (req_data),
        .rsp_valid   (rsp_valid),
        .rsp_data    (rsp_data),
        .bus_pull_low(bus_pull_low),
        .bus_in      (bus_line)
    );

    int    cyc = 0;
    int    checks = 0, fails = 0;
    int    ready_from = 0;
    bit    finished = 0;
    int    q_start[$], q_kind[$], q_bit[$];
    string q_tag[$];
    int    r_cyc[$], r_data[$];
    string r_tag[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", req, cyc, act, exp);
        end
    endtask

    // Behavioural timeline of slots, slave model and response expectations
    always @(negedge clk) begin
        if (!rst && !finished) begin
            bit    ep, erv;
            int    p;
            string tg;
            while (q_start.size() > 0 && cyc >= q_start[0] + SLOT) begin
                void'(q_start.pop_front()); void'(q_kind.pop_front());
                void'(q_bit.pop_front());   void'(q_tag.pop_front());
            end
            ep = 1'b0;
            tg = "R8";
            if (q_start.size() > 0 && cyc >= q_start[0]) begin
                p  = cyc - q_start[0];
                ep = p < ((q_kind[0] == 0) ? LOW0 : LOW1);
                tg = ep ? q_tag[0] : "R3";
                slave_low = (q_kind[0] == 2) && (q_bit[0] == 0) && (p >= 1) && (p < 40 * TPU);
                if (q_kind[0] != 2 && (p == 15 * TPU || p == 60 * TPU))
                    chk(bus_line == q_bit[0][0], q_tag[0], int'(bus_line), q_bit[0]);
            end else begin
                slave_low = 1'b0;
            end
            chk(bus_pull_low == ep, tg, int'(bus_pull_low), int'(ep));
            chk(req_ready == (cyc >= ready_from), "R8", int'(req_ready), int'(cyc >= ready_from));
            erv = (r_cyc.size() > 0) && (r_cyc[0] == cyc);
            chk(rsp_valid == erv, "R7", int'(rsp_valid), int'(erv));
            if (erv) begin
                chk(rsp_data == r_data[0][7:0], r_tag[0], int'(rsp_data), r_data[0]);
                void'(r_cyc.pop_front()); void'(r_data.pop_front()); void'(r_tag.pop_front());
            end
        end
    end

    // op: 0 write bit, 1 read bit, 2 write byte, 3 read byte
    task automatic issue(int op, int data);
        int  base, nsl, acc, last_end;
        bit  ok;
        req_op    = 2'(op);
        req_data  = 8'(data);
        req_valid = 1'b1;
        forever begin
            ok = req_ready;
            @(posedge clk); #1;
            if (ok) break;
        end
        req_valid = 1'b0;
        base = cyc + 1;
        nsl  = (op >= 2) ? 8 : 1;
        acc  = 0;
        for (int k = 0; k < nsl; k++) begin
            int b;
            if (op == 1 || op == 3) b = int'($urandom_range(1, 0));
            else                    b = (data >> k) & 1;
            q_start.push_back(base + k * (SLOT + 1));
            q_bit.push_back(b);
            if (op == 1 || op == 3) begin
                q_kind.push_back(2);
                q_tag.push_back(op == 1 ? "R2" : "R6");
                acc |= b << k;
            end else begin
                q_kind.push_back(b);
                q_tag.push_back(op == 2 ? "R5" : (b ? "R2" : "R1"));
            end
        end
        last_end   = base + (nsl - 1) * (SLOT + 1) + SLOT;
        ready_from = last_end;
        r_cyc.push_back(last_end);
        r_data.push_back((op == 1 || op == 3) ? acc : 0);
        r_tag.push_back(op == 1 ? "R4" : (op == 3 ? "R6" : "R7"));
    endtask

    task automatic wait_idle();
        while (r_cyc.size() > 0 || q_start.size() > 0) begin
            @(posedge clk); #1;
        end
        repeat (3) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(bus_pull_low == 1'b0, "R9", int'(bus_pull_low), 0);
        chk(req_ready == 1'b1, "R9", int'(req_ready), 1);
        chk(rsp_valid == 1'b0, "R9", int'(rsp_valid), 0);
        @(posedge clk); #1;
        rst = 1'b0;
        repeat (2) @(posedge clk);
        #1;

        issue(0, 0);          // R1 single write-0
        wait_idle();
        issue(0, 1);          // R2 single write-1
        wait_idle();
        issue(1, 0);          // R4 single read
        wait_idle();
        issue(1, 0);          // R4 polling: back-to-back reads
        issue(1, 0);
        issue(1, 0);
        wait_idle();
        issue(2, 8'hA5);      // R5 byte write
        // R8: stray valid while busy must start nothing
        req_op    = 2'd3;
        req_valid = 1'b1;
        repeat (30) begin
            @(posedge clk); #1;
        end
        req_valid = 1'b0;
        wait_idle();
        issue(2, 8'h3C);      // R5 and R7 overlap of response with next accept
        issue(3, 0);          // R6 byte read
        issue(3, 0);
        issue(0, 0);
        wait_idle();
        issue(2, 8'h00);      // R1 all-zero byte
        issue(2, 8'hFF);      // R2 all-one byte
        wait_idle();

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule